// File: doc/BRIEF.md
# Dual-Bank Descriptor Table

The block keeps 128 descriptors. Each descriptor has four 16-bit fields: a horizontal and a vertical position, plus a width and a height. A 32-bit write port fills the table one word at a time. The write address carries an entry number in its upper bits and a word offset in its three lowest bits. The offset decides which pair of fields the word lands in.

Positions and sizes live in two separate storage banks, so each bank can map onto a block memory of its own. Each bank has its own read index and its own registered 32-bit result. A consumer can therefore fetch the position of one descriptor and the size of a different descriptor in the same cycle. Storage is not initialised. A synchronous reset clears only the two read result registers.

Top module: `desc_table`

## Requirements
- R1: The 10-bit write address `wr_addr` splits into an entry number `wr_addr[9:3]` (0 to 127) and a word offset `wr_addr[2:0]`.
- R2: With offset 0, `wr_data[31:16]` becomes the entry's horizontal position and `wr_data[15:0]` its vertical position. A position read returns them as {horizontal, vertical} in bits 31:16 and 15:0.
- R3: With offset 1, `wr_data[31:16]` becomes the entry's width and `wr_data[15:0]` its height. A size read returns them as {width, height} in bits 31:16 and 15:0.
- R4: A write with an offset from 2 to 7 leaves both banks unchanged.
- R5: A write into one bank leaves the same entry in the other bank unchanged.
- R6: `pos_rdata` and `size_rdata` show the entries selected by `pos_idx` and `size_idx` one clock after those indices are sampled. The two indices are independent and may differ in the same cycle.
- R7: While `rst` is high at a clock edge, both read outputs become zero at that edge. The table contents survive the reset.
- R8: When a write and a read reach the same entry of the same bank at one edge, the read returns the contents from before the write. The new value appears on the following read.
- R9: Nothing is stored while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the read outputs, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Entry number in bits 9:3, word offset in bits 2:0 |
| wr_data | input | 32 | Write word |
| pos_idx | input | 7 | Entry selected for the position read |
| pos_rdata | output | 32 | Registered {horizontal, vertical} |
| size_idx | input | 7 | Entry selected for the size read |
| size_rdata | output | 32 | Registered {width, height} |

## Verification
Two pairs of functions can coincide at one clock edge. The first pair is a write and a read of the same entry in the same bank. The bench sets the write address and the read index to one entry together. It expects the old word in the cycle after the edge and the new word one read later. The second pair is the two read ports with different indices. The bench sets both indices at once and compares each result against its own bank's model.

// File: rtl/desc_table.sv
`timescale 1ns/1ps
module desc_table #(
  parameter int ENTRY_W = 7,
  parameter int OFS_W   = 3,
  parameter int FIELD_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ENTRY_W+OFS_W-1:0]   wr_addr,
  input  logic [2*FIELD_W-1:0]       wr_data,
  input  logic [ENTRY_W-1:0]         pos_idx,
  output logic [2*FIELD_W-1:0]       pos_rdata,
  input  logic [ENTRY_W-1:0]         size_idx,
  output logic [2*FIELD_W-1:0]       size_rdata
);
  localparam int DEPTH  = 1 << ENTRY_W;
  localparam int WORD_W = 2 * FIELD_W;
  localparam int BANKS  = 2;

  logic [ENTRY_W-1:0] wr_entry;
  logic [OFS_W-1:0]   wr_ofs;
  assign wr_entry = wr_addr[ENTRY_W+OFS_W-1:OFS_W];
  assign wr_ofs   = wr_addr[OFS_W-1:0];

  logic [ENTRY_W-1:0] rd_idx [BANKS];
  assign rd_idx[0] = pos_idx;
  assign rd_idx[1] = size_idx;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] q;
    logic              hit;
    assign hit = wr_en && (wr_ofs == OFS_W'(b));

    always_ff @(posedge clk) begin
      if (hit) mem[wr_entry] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= mem[rd_idx[b]];
    end
  end

  assign pos_rdata  = g_bank[0].q;
  assign size_rdata = g_bank[1].q;
endmodule

// File: rtl/desc_table_chk.sv
`timescale 1ns/1ps
module desc_table_chk #(
  parameter int ENTRY_W = 7,
  parameter int OFS_W   = 3,
  parameter int FIELD_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ENTRY_W+OFS_W-1:0] wr_addr,
  input logic [2*FIELD_W-1:0]     wr_data,
  input logic [ENTRY_W-1:0]       pos_idx,
  input logic [2*FIELD_W-1:0]     pos_rdata,
  input logic [ENTRY_W-1:0]       size_idx,
  input logic [2*FIELD_W-1:0]     size_rdata
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  logic [OFS_W-1:0]   ofs;
  logic [ENTRY_W-1:0] ent;
  assign ofs = wr_addr[OFS_W-1:0];
  assign ent = wr_addr[ENTRY_W+OFS_W-1:OFS_W];

  AST_RST_CLEARS_READS: assert property (@(posedge clk)
    rst |=> (pos_rdata == '0 && size_rdata == '0)); // R7

  AST_POS_HOLDS_WITHOUT_POS_WRITE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($stable(pos_idx) && !($past(wr_en) && $past(ofs) == OFS_W'(0))) |=> $stable(pos_rdata)); // R4

  AST_SIZE_HOLDS_WITHOUT_SIZE_WRITE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($stable(size_idx) && !($past(wr_en) && $past(ofs) == OFS_W'(1))) |=> $stable(size_rdata)); // R5

  AST_POS_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wr_en) && $past(ofs) == OFS_W'(0) && $past(ent) == pos_idx)
      |=> (pos_rdata == $past(wr_data, 2))); // R2

  AST_SIZE_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wr_en) && $past(ofs) == OFS_W'(1) && $past(ent) == size_idx)
      |=> (size_rdata == $past(wr_data, 2))); // R3
endmodule

bind desc_table desc_table_chk #(
  .ENTRY_W(ENTRY_W), .OFS_W(OFS_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pos_idx(pos_idx), .pos_rdata(pos_rdata), .size_idx(size_idx), .size_rdata(size_rdata)
);

// File: tb/desc_table_tb.sv
`timescale 1ns/1ps
module desc_table_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  pos_idx = '0;
  logic [6:0]  size_idx = '0;
  logic [31:0] pos_rdata, size_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] pos_m  [128];
  logic [31:0] size_m [128];

  always #4 clk = ~clk;

  desc_table u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pos_idx(pos_idx), .pos_rdata(pos_rdata), .size_idx(size_idx), .size_rdata(size_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic write_word(input int e, input int ofs, input logic [31:0] d, input bit en = 1'b1);
    wr_en   = en;
    wr_addr = {7'(e), 3'(ofs)};
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (en && ofs == 0) pos_m[e]  = d;
    if (en && ofs == 1) size_m[e] = d;
  endtask

  task automatic read_pair(input int p, input int s, input string req);
    pos_idx  = 7'(p);
    size_idx = 7'(s);
    @(posedge clk);
    @(negedge clk);
    check(req, pos_rdata, pos_m[p]);
    check(req, size_rdata, size_m[s]);
  endtask

  task automatic t_reset;
    check("R7 reset pos", pos_rdata, 32'h0);
    check("R7 reset size", size_rdata, 32'h0);
  endtask

  task automatic t_fill_and_sweep;
    for (int e = 0; e < 128; e++) begin
      write_word(e, 0, 32'h1000_0000 + e * 32'h0001_0003);
      write_word(e, 1, 32'h2000_ffff - e * 32'h0002_0001);
    end
    for (int e = 0; e < 128; e++) read_pair(e, e, "R1 R2 R3 sweep");
  endtask

  task automatic t_field_split;
    write_word(9, 0, 32'hAAAA_5555);
    write_word(9, 1, 32'h0102_0304);
    pos_idx = 7'd9; size_idx = 7'd9;
    @(posedge clk); @(negedge clk);
    check("R2 x field", {16'h0, pos_rdata[31:16]}, 32'h0000_AAAA);
    check("R2 y field", {16'h0, pos_rdata[15:0]}, 32'h0000_5555);
    check("R3 width field", {16'h0, size_rdata[31:16]}, 32'h0000_0102);
    check("R3 height field", {16'h0, size_rdata[15:0]}, 32'h0000_0304);
  endtask

  task automatic t_bad_offsets;
    for (int o = 2; o < 8; o++) write_word(40, o, 32'hDEAD_0000 + 32'(o));
    read_pair(40, 40, "R4 offsets 2..7 ignored");
    write_word(41, 0, 32'hBEEF_BEEF, 1'b0);
    write_word(41, 1, 32'hBEEF_BEEF, 1'b0);
    read_pair(41, 41, "R9 no store without wr_en");
  endtask

  task automatic t_bank_isolation;
    write_word(60, 0, 32'h6060_0606);
    read_pair(60, 60, "R5 pos write leaves size");
    write_word(61, 1, 32'h6161_1616);
    read_pair(61, 61, "R5 size write leaves pos");
  endtask

  task automatic t_split_reads;
    read_pair(3, 120, "R6 different indices");
    read_pair(127, 0, "R6 extreme indices");
    read_pair(64, 63, "R6 adjacent indices");
  endtask

  task automatic t_read_before_write;
    logic [31:0] old_p;
    logic [31:0] old_s;
    old_p = pos_m[77];
    old_s = size_m[78];
    pos_idx = 7'd77; size_idx = 7'd78;
    wr_en = 1'b1; wr_addr = {7'd77, 3'd0}; wr_data = 32'h7777_0077;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    pos_m[77] = 32'h7777_0077;
    check("R8 pos old value", pos_rdata, old_p);
    @(posedge clk); @(negedge clk);
    check("R8 pos new value", pos_rdata, 32'h7777_0077);
    wr_en = 1'b1; wr_addr = {7'd78, 3'd1}; wr_data = 32'h7878_0078;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    size_m[78] = 32'h7878_0078;
    check("R8 size old value", size_rdata, old_s);
    @(posedge clk); @(negedge clk);
    check("R8 size new value", size_rdata, 32'h7878_0078);
  endtask

  task automatic t_reset_keeps_table;
    pos_idx = 7'd9; size_idx = 7'd9;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 mid reset pos", pos_rdata, 32'h0);
    check("R7 mid reset size", size_rdata, 32'h0);
    rst = 1'b0;
    read_pair(9, 61, "R7 contents survive reset");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_fill_and_sweep();
    t_field_split();
    t_bad_offsets();
    t_bank_isolation();
    t_split_reads();
    t_read_before_write();
    t_reset_keeps_table();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule